// File: doc/BRIEF.md
# Reset-Time Bus Mode and Frequency Resolver

This block acts as the central resource of one parallel PCI / PCI-X bus segment. It decides whether the segment runs conventional PCI or PCI-X, and at which clock frequency. While the segment reset is held low, it watches three inputs. The first is the 66 MHz enable pin. The second is a 2-bit code that an analog front end derives from the PCI-X capability pin level. The third is an active-low board strap, set by the board designer when slot loading limits PCI-X operation to 100 MHz. All of these inputs are asynchronous, so each is passed through a synchronizer before use.

Once the segment reset is released, the block settles on one configuration and latches it. The result is never taken from the card report alone or from the strap alone. The frequency is the lowest of three ceilings: the one the card reports, the controller's own ceiling, and the strap limit. The latched mode, the frequency code and a valid flag then hold steady until the segment reset is asserted again. The clock generator and the bus initialization logic read these outputs.

Top module: `pbm_bus_mode_resolver`

## Requirements
- R1: While the synchronized segment reset is low, and after chip reset, `cfg_valid` is 0, `bus_pcix` is 0 and `bus_freq` is 0 (33 MHz). Frequency codes: 0 = 33 MHz, 1 = 66 MHz, 2 = 100 MHz, 3 = 133 MHz.
- R2: With `pcix_cap` = 00 (not PCI-X capable) and `m66_en` low, the result is conventional mode (`bus_pcix` = 0) at code 0.
- R3: With `pcix_cap` = 00 and `m66_en` high, the result is conventional mode at code 1. The 100 MHz strap has no effect in conventional mode.
- R4: With `pcix_cap` = 01 (PCI-X 66), the result is PCI-X mode (`bus_pcix` = 1) at code 1, whatever the values of `m66_en` and the strap.
- R5: With `pcix_cap` = 10 (PCI-X 133), the result is PCI-X at code 3 when `lim100_n` is high, and at code 2 when `lim100_n` is low.
- R6: With `pcix_cap` = 11 (PCI-X 266), the result is clipped to the controller ceiling: code 3 when `lim100_n` is high, and code 2 when it is low.
- R7: After `seg_rst_n` rises, `cfg_valid` stays low for SYNC_STAGES rising clock edges and is high after edge SYNC_STAGES+1, carrying the inputs sampled while reset was low.
- R8: Once `cfg_valid` is high, changes on `m66_en`, `pcix_cap` and `lim100_n` do not alter `bus_pcix` or `bus_freq`. The outputs hold until a new segment reset reaches the synchronizer.
- R9: When `seg_rst_n` is asserted again, `cfg_valid` falls after SYNC_STAGES+1 edges, and the next release resolves from the new input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip reset, asynchronous assert, active low |
| seg_rst_n | input | 1 | Bus segment reset, active low, asynchronous |
| m66_en | input | 1 | 66 MHz enable pin level |
| pcix_cap | input | 2 | Digitized PCI-X capability level (00 none, 01 X66, 10 X133, 11 X266) |
| lim100_n | input | 1 | Board strap, low caps PCI-X at 100 MHz |
| bus_pcix | output | 1 | 1 = PCI-X mode, 0 = conventional |
| bus_freq | output | 2 | Frequency code (0 = 33, 1 = 66, 2 = 100, 3 = 133 MHz) |
| cfg_valid | output | 1 | Latched configuration is valid |

## Verification
The bench builds the block with SYNC_STAGES = 2 and the controller ceiling at its default of 133 MHz. With these values, every capability code can be combined with both strap levels. This includes the 266-capable card, which must be clipped first by the controller ceiling and then by the strap. Because the bench takes the synchronizer depth from the same parameter, it can pin down the exact release edge: valid must still be low after two edges and high after the third. The same edge count is used for the clear on a new segment reset.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [1:0] {
    FRQ_33  = 2'd0,
    FRQ_66  = 2'd1,
    FRQ_100 = 2'd2,
    FRQ_133 = 2'd3
  } bus_freq_e;

  typedef enum logic [1:0] {
    XCAP_NONE = 2'd0,
    XCAP_66   = 2'd1,
    XCAP_133  = 2'd2,
    XCAP_266  = 2'd3
  } xcap_e;

  typedef struct packed {
    logic      pcix;
    bus_freq_e freq;
  } bus_cfg_t;

  localparam bus_cfg_t CFG_IDLE = '{pcix: 1'b0, freq: FRQ_33};

  function automatic bus_freq_e freq_min(input bus_freq_e a, input bus_freq_e b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/pbm_sync.sv
module pbm_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/pbm_resolve.sv
module pbm_resolve
  import pbm_pkg::*;
#(
  parameter bus_freq_e CTRL_MAX_FREQ = FRQ_133,
  parameter bus_freq_e STRAP_FREQ    = FRQ_100
) (
  input  logic     m66_en,
  input  xcap_e    cap,
  input  logic     lim100_n,
  output bus_cfg_t cfg
);

  bus_freq_e dev_ceiling;
  bus_freq_e board_ceiling;

  always_comb begin
    unique case (cap)
      XCAP_66:  dev_ceiling = FRQ_66;
      XCAP_133: dev_ceiling = FRQ_133;
      XCAP_266: dev_ceiling = FRQ_133;
      default:  dev_ceiling = m66_en ? FRQ_66 : FRQ_33;
    endcase
  end

  assign board_ceiling = lim100_n ? CTRL_MAX_FREQ : freq_min(CTRL_MAX_FREQ, STRAP_FREQ);

  always_comb begin
    cfg = CFG_IDLE;
    if (cap == XCAP_NONE) begin
      cfg.pcix = 1'b0;
      cfg.freq = dev_ceiling;
    end else begin
      cfg.pcix = 1'b1;
      cfg.freq = freq_min(dev_ceiling, board_ceiling);
    end
  end

  always_comb begin
    if (cfg.pcix && !lim100_n)
      AST_STRAP_CAP: assert (cfg.freq <= STRAP_FREQ);               // R5
    if (!cfg.pcix)
      AST_CONV_FREQ: assert (cfg.freq == FRQ_33 || cfg.freq == FRQ_66); // R3
  end

endmodule

// File: rtl/pbm_latch.sv
module pbm_latch
  import pbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     seg_rst_s,
  input  bus_cfg_t cfg_in,
  output bus_cfg_t cfg_q,
  output logic     valid_q
);

  bus_cfg_t cfg_d;
  logic     valid_d;
  logic     cfg_en;

  always_comb begin
    cfg_d   = cfg_q;
    valid_d = valid_q;
    cfg_en  = 1'b0;
    if (!seg_rst_s) begin
      cfg_d   = CFG_IDLE;
      valid_d = 1'b0;
      cfg_en  = 1'b1;
    end else if (!valid_q) begin
      cfg_d   = cfg_in;
      valid_d = 1'b1;
      cfg_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cfg_q   <= CFG_IDLE;
    end else begin
      valid_q <= valid_d;
      if (cfg_en) cfg_q <= cfg_d;
    end
  end

  AST_NO_VALID_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_rst_s |=> !valid_q);                                        // R1
  AST_VALID_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(seg_rst_s));                            // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && seg_rst_s) |=> (valid_q && $stable(cfg_q)));         // R8

endmodule

// File: rtl/pbm_bus_mode_resolver.sv
module pbm_bus_mode_resolver
  import pbm_pkg::*;
#(
  parameter int        SYNC_STAGES   = 2,
  parameter bus_freq_e CTRL_MAX_FREQ = FRQ_133
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seg_rst_n,
  input  logic       m66_en,
  input  logic [1:0] pcix_cap,
  input  logic       lim100_n,
  output logic       bus_pcix,
  output logic [1:0] bus_freq,
  output logic       cfg_valid
);

  localparam int PIN_W = 4;

  logic [PIN_W-1:0] pins_async;
  logic [PIN_W-1:0] pins_s;
  logic             seg_rst_s;
  bus_cfg_t         cfg_res;
  bus_cfg_t         cfg_q;
  logic             valid_q;

  assign pins_async = {m66_en, pcix_cap, lim100_n};

  pbm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (seg_rst_n),
    .q_sync  (seg_rst_s)
  );

  pbm_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins_async),
    .q_sync  (pins_s)
  );

  pbm_resolve #(.CTRL_MAX_FREQ(CTRL_MAX_FREQ), .STRAP_FREQ(FRQ_100)) u_resolve (
    .m66_en   (pins_s[3]),
    .cap      (xcap_e'(pins_s[2:1])),
    .lim100_n (pins_s[0]),
    .cfg      (cfg_res)
  );

  pbm_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_rst_s (seg_rst_s),
    .cfg_in    (cfg_res),
    .cfg_q     (cfg_q),
    .valid_q   (valid_q)
  );

  assign bus_pcix  = cfg_q.pcix;
  assign bus_freq  = cfg_q.freq;
  assign cfg_valid = valid_q;

  AST_PCIX_66_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && bus_pcix) |-> (bus_freq != FRQ_33));               // R4

endmodule

// File: tb/tb_pbm_bus_mode_resolver.sv
module tb_pbm_bus_mode_resolver;

  localparam int SYNC = 2;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       seg_rst_n;
  logic       m66_en;
  logic [1:0] pcix_cap;
  logic       lim100_n;
  logic       bus_pcix;
  logic [1:0] bus_freq;
  logic       cfg_valid;

  int checks = 0;
  int failures = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic       prev_valid = 1'b0;
  logic [2:0] last_exp = '0;

  always #2 clk = ~clk;

  pbm_bus_mode_resolver #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .seg_rst_n(seg_rst_n), .m66_en(m66_en),
    .pcix_cap(pcix_cap), .lim100_n(lim100_n), .bus_pcix(bus_pcix),
    .bus_freq(bus_freq), .cfg_valid(cfg_valid)
  );

  task automatic chk(input logic ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] model(input logic m66, input logic [1:0] cap, input logic lim_n);
    if (cap == 2'b00) return {1'b0, m66 ? 2'd1 : 2'd0};
    if (cap == 2'b01) return {1'b1, 2'd1};
    return {1'b1, lim_n ? 2'd3 : 2'd2};
  endfunction

  task automatic run_case(input logic m66, input logic [1:0] cap, input logic lim_n, input string req);
    @(negedge clk);
    seg_rst_n = 1'b0;
    m66_en = m66; pcix_cap = cap; lim100_n = lim_n;
    repeat (SYNC + 3) @(negedge clk);
    chk(cfg_valid == 1'b0 && bus_pcix == 1'b0 && bus_freq == 2'd0, "R1",
        {1'b0, cfg_valid, bus_pcix, bus_freq[0]}, 4'h0);
    last_exp = model(m66, cap, lim_n);
    exp_q.push_back(last_exp);
    tag_q.push_back(req);
    seg_rst_n = 1'b1;
    repeat (SYNC) @(negedge clk);
    chk(cfg_valid == 1'b0, "R7 valid early", {3'b0, cfg_valid}, 4'h0);
    @(negedge clk);
    chk(cfg_valid == 1'b1, "R7 valid late", {3'b0, cfg_valid}, 4'h1);
    repeat (2) @(negedge clk);
  endtask

  // Scoreboard monitor: compare on each rising valid.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (cfg_valid && !prev_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected valid", {1'b0, bus_pcix, bus_freq}, 4'hf);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({bus_pcix, bus_freq} == e, t, {1'b0, bus_pcix, bus_freq}, {1'b0, e});
        end
      end
      prev_valid <= cfg_valid;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R7 watchdog expired", 4'h0, 4'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; seg_rst_n = 1'b0; m66_en = 1'b0; pcix_cap = 2'b00; lim100_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg_valid == 1'b0 && bus_pcix == 1'b0 && bus_freq == 2'd0, "R1 chip reset",
        {1'b0, cfg_valid, bus_pcix, bus_freq[0]}, 4'h0);
    rst_n = 1'b1;

    run_case(1'b0, 2'b00, 1'b1, "R2 conv 33");
    run_case(1'b1, 2'b00, 1'b1, "R3 conv 66");
    run_case(1'b1, 2'b00, 1'b0, "R3 conv 66 strap ignored");
    run_case(1'b0, 2'b00, 1'b0, "R2 conv 33 strap ignored");
    run_case(1'b0, 2'b01, 1'b1, "R4 X66");
    run_case(1'b1, 2'b01, 1'b0, "R4 X66 strap");
    run_case(1'b0, 2'b10, 1'b1, "R5 X133");
    run_case(1'b1, 2'b10, 1'b0, "R5 X133 capped 100");
    run_case(1'b1, 2'b11, 1'b1, "R6 X266 clipped 133");
    run_case(1'b0, 2'b11, 1'b0, "R6 X266 capped 100");

    // R8: input changes after latch are ignored.
    m66_en = 1'b1; pcix_cap = 2'b00; lim100_n = 1'b1;
    repeat (8) @(negedge clk);
    chk({bus_pcix, bus_freq} == last_exp && cfg_valid, "R8 hold",
        {cfg_valid, bus_pcix, bus_freq}, {1'b1, last_exp});

    // R9: new segment reset clears after SYNC+1 edges.
    seg_rst_n = 1'b0;
    repeat (SYNC) @(negedge clk);
    chk(cfg_valid == 1'b1 && {bus_pcix, bus_freq} == last_exp, "R8 hold until reset sync",
        {cfg_valid, bus_pcix, bus_freq}, {1'b1, last_exp});
    @(negedge clk);
    chk(cfg_valid == 1'b0 && bus_pcix == 1'b0 && bus_freq == 2'd0, "R9 clear",
        {cfg_valid, bus_pcix, bus_freq}, 4'h0);
    run_case(1'b1, 2'b00, 1'b1, "R9 re-resolve");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all results seen", 4'(exp_q.size()), 4'h0);
    finish_run();
  end

endmodule